// File: doc/BRIEF.md
# Context Relocation Bit-Merge Unit

This unit moves saved flip-flop state from one configuration image into another. A region's captured state lives in a capture word store, together with a mask word store that marks which captured bits are real state. A different destination region has its own initial configuration image. The unit takes a stream of update entries. Each entry names a source word index and a bit position in that word. It also names a destination word index and a bit position there.

For every entry the unit reads the captured word and its mask word. It keeps only the selected, masked source bit and shifts it by the signed distance between the two bit positions. It clears the selected bit in the current destination word, ORs in the shifted bit and writes the word back.

Several entries that land in the same destination word are applied strictly in order. Each one starts from the result the previous one produced. The unit forwards in-flight results, so it never stalls and accepts one entry on every clock. An entry can be flagged as the last of a batch, and the unit pulses `done` once that entry's write has reached memory.

Top module: `ctx_reloc_merge`

## Requirements
- R1: For an entry (s, ps, d, pd), bit pd of the written word equals bit ps of capture word s ANDed with bit ps of mask word s. All other bits of the written word equal the current content of destination word d. Capture and mask bits at positions other than ps have no effect.
- R2: When ps is greater than pd, the source bit moves down by ps−pd positions.
- R3: When ps is less than pd, the source bit moves up by pd−ps positions.
- R4: When ps equals pd, the bit keeps its position.
- R5: When mask bit ps of word s is 0, bit pd of the written word becomes 0 even if the captured bit is 1.
- R6: Entries that target the same destination word at gaps of 0, 1, 2 or more cycles are each applied on top of the result of all earlier entries. The destination image ends as if the entries had been applied one at a time.
- R7: One entry is accepted on every cycle that `in_valid` is high. Its write appears on `dst_wr_en`/`dst_wr_addr`/`dst_wr_data` exactly two cycles later, at address d, in entry order. `src_rd_addr` and `dst_rd_addr` present s and d in the acceptance cycle, and read data is expected one cycle later.
- R8: `done` is high for one cycle, exactly one cycle after the write of an entry accepted with `in_last` high, and at no other time.
- R9: While `rst` is high, and in the cycle after it falls, no write is issued and `done` is low. Entries presented during reset are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Update entry present this cycle |
| in_last | input | 1 | Entry is the last of its batch |
| in_src_idx | input | SRC_AW | Source capture/mask word index |
| in_src_pos | input | 5 | Bit position in the source word |
| in_dst_idx | input | DST_AW | Destination image word index |
| in_dst_pos | input | 5 | Bit position in the destination word |
| src_rd_addr | output | SRC_AW | Read address for capture and mask stores |
| dst_rd_addr | output | DST_AW | Read address for the destination image |
| src_cap_rdata | input | 32 | Captured word, one cycle after its address |
| src_msk_rdata | input | 32 | Source mask word, one cycle after its address |
| dst_rdata | input | 32 | Destination image word, one cycle after its address |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_wr_addr | output | DST_AW | Destination write address |
| dst_wr_data | output | 32 | Merged word to write |
| done | output | 1 | Last entry of a batch has been written |

## Verification
The bound checker watches the timing skeleton on every cycle. It confirms that each accepted entry produces a write two cycles later at the same destination index, that `done` only follows a write of a last-flagged entry, and that reset leaves both strobes quiet. The contents of merged words can only be judged by the bench's scenarios. These cover the shift direction and the mask cases, and they run bursts of entries aimed at one destination word with zero, one and two idle cycles between them. A reference image rebuilt one bit at a time catches any lost or stale read-after-write result.

// File: rtl/ctx_reloc_pkg.sv
package ctx_reloc_pkg;

    localparam int WORD_W = 32;
    localparam int POS_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [POS_W-1:0]  pos_t;

    // signed bit distance folded into a direction flag and a magnitude
    typedef struct packed {
        logic toward_lsb;
        pos_t amount;
    } shift_t;

    function automatic word_t bit_select(input pos_t p);
        return word_t'(1) << p;
    endfunction

    function automatic shift_t bit_distance(input pos_t src_p, input pos_t dst_p);
        shift_t r;
        if (src_p >= dst_p) begin
            r.toward_lsb = 1'b1;
            r.amount     = src_p - dst_p;
        end else begin
            r.toward_lsb = 1'b0;
            r.amount     = dst_p - src_p;
        end
        return r;
    endfunction

endpackage

// File: rtl/ctx_reloc_issue.sv
module ctx_reloc_issue
    import ctx_reloc_pkg::*;
#(
    parameter int DST_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  pos_t              in_src_pos,
    input  logic [DST_AW-1:0] in_dst_idx,
    input  pos_t              in_dst_pos,
    output logic              s1_valid,
    output logic              s1_last,
    output logic [DST_AW-1:0] s1_dst_idx,
    output word_t             s1_src_sel,
    output word_t             s1_dst_sel,
    output shift_t            s1_shift
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid   <= 1'b0;
            s1_last    <= 1'b0;
            s1_dst_idx <= '0;
            s1_src_sel <= '0;
            s1_dst_sel <= '0;
            s1_shift   <= '0;
        end else begin
            s1_valid   <= in_valid;
            s1_last    <= in_valid & in_last;
            s1_dst_idx <= in_dst_idx;
            s1_src_sel <= bit_select(in_src_pos);
            s1_dst_sel <= bit_select(in_dst_pos);
            s1_shift   <= bit_distance(in_src_pos, in_dst_pos);
        end
    end

endmodule

// File: rtl/ctx_reloc_fwd.sv
module ctx_reloc_fwd
    import ctx_reloc_pkg::*;
#(
    parameter int DST_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DST_AW-1:0] look_idx,
    input  word_t             mem_word,
    input  logic              wr_en,
    input  logic [DST_AW-1:0] wr_idx,
    input  word_t             wr_word,
    output word_t             base_word
);

    // the write retired one cycle ago raced the current read
    logic              old_en;
    logic [DST_AW-1:0] old_idx;
    word_t             old_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            old_en   <= 1'b0;
            old_idx  <= '0;
            old_word <= '0;
        end else begin
            old_en   <= wr_en;
            old_idx  <= wr_idx;
            old_word <= wr_word;
        end
    end

    always_comb begin
        if (wr_en && wr_idx == look_idx)
            base_word = wr_word;
        else if (old_en && old_idx == look_idx)
            base_word = old_word;
        else
            base_word = mem_word;
    end

endmodule

// File: rtl/ctx_reloc_align.sv
module ctx_reloc_align
    import ctx_reloc_pkg::*;
(
    input  word_t  cap_word,
    input  word_t  msk_word,
    input  word_t  src_sel,
    input  word_t  dst_sel,
    input  shift_t shift,
    input  word_t  base_word,
    output word_t  merged
);

    word_t picked;
    word_t moved;

    always_comb begin
        picked = cap_word & msk_word & src_sel;
        if (shift.toward_lsb)
            moved = picked >> shift.amount;
        else
            moved = picked << shift.amount;
        merged = moved | (base_word & ~dst_sel);
    end

endmodule

// File: rtl/ctx_reloc_merge.sv
module ctx_reloc_merge
    import ctx_reloc_pkg::*;
#(
    parameter int SRC_AW = 8,
    parameter int DST_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [SRC_AW-1:0] in_src_idx,
    input  logic [4:0]        in_src_pos,
    input  logic [DST_AW-1:0] in_dst_idx,
    input  logic [4:0]        in_dst_pos,
    output logic [SRC_AW-1:0] src_rd_addr,
    output logic [DST_AW-1:0] dst_rd_addr,
    input  logic [31:0]       src_cap_rdata,
    input  logic [31:0]       src_msk_rdata,
    input  logic [31:0]       dst_rdata,
    output logic              dst_wr_en,
    output logic [DST_AW-1:0] dst_wr_addr,
    output logic [31:0]       dst_wr_data,
    output logic              done
);

    logic              s1_valid;
    logic              s1_last;
    logic [DST_AW-1:0] s1_dst_idx;
    word_t             s1_src_sel;
    word_t             s1_dst_sel;
    shift_t            s1_shift;
    word_t             base_word;
    word_t             merged;
    logic              s2_last;

    assign src_rd_addr = in_src_idx;
    assign dst_rd_addr = in_dst_idx;

    ctx_reloc_issue #(.DST_AW(DST_AW)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_src_pos (in_src_pos),
        .in_dst_idx (in_dst_idx),
        .in_dst_pos (in_dst_pos),
        .s1_valid   (s1_valid),
        .s1_last    (s1_last),
        .s1_dst_idx (s1_dst_idx),
        .s1_src_sel (s1_src_sel),
        .s1_dst_sel (s1_dst_sel),
        .s1_shift   (s1_shift)
    );

    ctx_reloc_fwd #(.DST_AW(DST_AW)) u_fwd (
        .clk       (clk),
        .rst       (rst),
        .look_idx  (s1_dst_idx),
        .mem_word  (dst_rdata),
        .wr_en     (dst_wr_en),
        .wr_idx    (dst_wr_addr),
        .wr_word   (dst_wr_data),
        .base_word (base_word)
    );

    ctx_reloc_align u_align (
        .cap_word  (src_cap_rdata),
        .msk_word  (src_msk_rdata),
        .src_sel   (s1_src_sel),
        .dst_sel   (s1_dst_sel),
        .shift     (s1_shift),
        .base_word (base_word),
        .merged    (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_wr_en   <= 1'b0;
            dst_wr_addr <= '0;
            dst_wr_data <= '0;
            s2_last     <= 1'b0;
            done        <= 1'b0;
        end else begin
            dst_wr_en   <= s1_valid;
            dst_wr_addr <= s1_dst_idx;
            dst_wr_data <= merged;
            s2_last     <= s1_last;
            done        <= dst_wr_en & s2_last;
        end
    end

endmodule

// File: rtl/ctx_reloc_merge_chk.sv
module ctx_reloc_merge_chk #(
    parameter int DST_AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_last,
    input logic [DST_AW-1:0] in_dst_idx,
    input logic              dst_wr_en,
    input logic [DST_AW-1:0] dst_wr_addr,
    input logic              done
);

    // R7: every accepted entry writes two cycles later
    assert_write_follows_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 dst_wr_en);

    // R7: write address is the entry's destination index
    assert_write_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (dst_wr_en && $past(in_valid, 2)) |-> dst_wr_addr == $past(in_dst_idx, 2));

    // R8: done only after the write of a last-flagged entry
    assert_done_cause_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(dst_wr_en) && $past(in_valid, 3) && $past(in_last, 3)));

    // R9: reset keeps both strobes low in the following cycle
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!dst_wr_en && !done));

endmodule

bind ctx_reloc_merge ctx_reloc_merge_chk #(.DST_AW(DST_AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .in_dst_idx  (in_dst_idx),
    .dst_wr_en   (dst_wr_en),
    .dst_wr_addr (dst_wr_addr),
    .done        (done)
);

// File: tb/ctx_reloc_merge_bench.sv
`timescale 1ns/1ps
module ctx_reloc_merge_bench;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic [AW-1:0] in_src_idx = '0;
    logic [4:0]    in_src_pos = '0;
    logic [AW-1:0] in_dst_idx = '0;
    logic [4:0]    in_dst_pos = '0;
    logic [AW-1:0] src_rd_addr;
    logic [AW-1:0] dst_rd_addr;
    logic [31:0]   src_cap_rdata;
    logic [31:0]   src_msk_rdata;
    logic [31:0]   dst_rdata;
    logic          dst_wr_en;
    logic [AW-1:0] dst_wr_addr;
    logic [31:0]   dst_wr_data;
    logic          done;

    always #2.5 clk = ~clk;

    ctx_reloc_merge #(.SRC_AW(AW), .DST_AW(AW)) u_ctx_reloc_merge (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_src_idx(in_src_idx), .in_src_pos(in_src_pos),
        .in_dst_idx(in_dst_idx), .in_dst_pos(in_dst_pos),
        .src_rd_addr(src_rd_addr), .dst_rd_addr(dst_rd_addr),
        .src_cap_rdata(src_cap_rdata), .src_msk_rdata(src_msk_rdata),
        .dst_rdata(dst_rdata), .dst_wr_en(dst_wr_en),
        .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data), .done(done)
    );

    // memories with one-cycle read latency, old data on read-during-write
    logic [31:0] cap_mem [DEPTH];
    logic [31:0] msk_mem [DEPTH];
    logic [31:0] dst_mem [DEPTH];
    logic [31:0] golden  [DEPTH];

    always @(posedge clk) begin
        src_cap_rdata <= cap_mem[src_rd_addr];
        src_msk_rdata <= msk_mem[src_rd_addr];
        dst_rdata     <= dst_mem[dst_rd_addr];
        if (dst_wr_en) dst_mem[dst_wr_addr] <= dst_wr_data;
    end

    typedef struct {
        logic [AW-1:0] addr;
        logic [31:0]   data;
        bit            last;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   prev_last_wr = 1'b0;
    bit   run_over = 1'b0;

    function automatic logic [31:0] ref_bit(input logic [31:0] ini, input logic [31:0] cap,
                                            input logic [31:0] msk, input int sp, input int dp);
        logic [31:0] r;
        r = ini;
        r[dp] = cap[sp] & msk[sp];
        return r;
    endfunction

    task automatic send(input int s, input int sp, input int d, input int dp,
                        input bit last, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid   = 1'b1;
        in_last    = last;
        in_src_idx = AW'(s);
        in_src_pos = 5'(sp);
        in_dst_idx = AW'(d);
        in_dst_pos = 5'(dp);
        golden[d]  = ref_bit(golden[d], cap_mem[s], msk_mem[s], sp, dp);
        e.addr = AW'(d);
        e.data = golden[d];
        e.last = last;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (done !== prev_last_wr) begin
                fails++;
                $display("FAIL R8 done actual=%b expected=%b", done, prev_last_wr);
            end
            prev_last_wr = 1'b0;
            if (dst_wr_en) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R7 unexpected write addr=%0h data=%h actual=1 expected=0",
                             dst_wr_addr, dst_wr_data);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (dst_wr_addr !== e.addr || dst_wr_data !== e.data) begin
                        fails++;
                        $display("FAIL %s write actual=%0h:%h expected=%0h:%h",
                                 e.tag, dst_wr_addr, dst_wr_data, e.addr, e.data);
                    end
                    prev_last_wr = e.last;
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            cap_mem[i] = 32'h9E37_79B9 * (i + 1);
            msk_mem[i] = 32'hA5C3_0F69 ^ (32'h0101_0101 * i);
            dst_mem[i] = 32'h6D2B_79F5 * (i + 3);
        end
        cap_mem[10] = 32'hFFFF_FFFF; msk_mem[10] = 32'hFFFF_0000;
        cap_mem[11] = 32'h0000_0000; msk_mem[11] = 32'hFFFF_FFFF;
        cap_mem[12] = 32'hFFFF_FFFF; msk_mem[12] = 32'hFFFF_FFFF;
        dst_mem[20] = 32'hFFFF_FFFF; dst_mem[21] = 32'h0000_0000;
        dst_mem[22] = 32'h0000_0000;
        for (int i = 0; i < DEPTH; i++) golden[i] = dst_mem[i];

        // R9: entries during reset are dropped
        @(negedge clk);
        in_valid = 1'b1; in_last = 1'b1; in_dst_idx = 8'd40;
        repeat (3) @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (dst_wr_en !== 1'b0 || done !== 1'b0) begin
                fails++;
                $display("FAIL R9 wr_en/done actual=%b%b expected=00", dst_wr_en, done);
            end
        end

        // R2 right move, R3 left move, R4 same position
        send(3, 20, 5, 7, 1'b0, "R2");
        send(4, 2, 6, 29, 1'b0, "R3");
        send(7, 13, 8, 13, 1'b1, "R4");
        idle(5);

        // R5: masked-off source bit clears destination; R1 other bits untouched
        send(10, 4, 20, 9, 1'b0, "R5");
        send(10, 20, 21, 0, 1'b0, "R1");
        send(11, 31, 20, 31, 1'b0, "R1");
        send(12, 0, 22, 31, 1'b1, "R3");
        idle(5);

        // R6: same destination word at gaps 0, 1, 2
        send(12, 1, 30, 1, 1'b0, "R6");
        send(12, 2, 30, 5, 1'b0, "R6");
        send(11, 5, 30, 5, 1'b0, "R6");
        send(12, 31, 30, 0, 1'b0, "R6");
        idle(1);
        send(10, 17, 30, 3, 1'b0, "R6");
        idle(2);
        send(11, 3, 30, 3, 1'b1, "R6");
        idle(1);
        send(12, 9, 30, 18, 1'b1, "R8");
        idle(5);

        // R7: dense stream over a few words, mixed directions
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int k = 0; k < 60; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                send(int'(lf[3:0]), int'(lf[8:4]), 50 + int'(lf[10:9]),
                     int'(lf[15:11]), (k == 59), "R7");
            end
        end
        idle(6);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7 pending writes actual=%0d expected=0", exp_q.size());
        end
        for (int i = 0; i < 64; i++) begin
            checks++;
            if (dst_mem[i] !== golden[i]) begin
                fails++;
                $display("FAIL R6 image word %0d actual=%h expected=%h", i, dst_mem[i], golden[i]);
            end
        end
        run_over = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!run_over) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule